// File: doc/BRIEF.md
# Asymmetric Baseline Drift Tracker

This block keeps one 16-bit baseline value per sense channel of a four-channel capacitive touch front end, and it decides when each measurement happens. After reset it waits a start-up interval and then takes a quick run of acquisitions with no sleep between them. The baseline of each channel is the mean of that run. Once that is done, it goes into a sleep/wake loop. Each pass sleeps for a short or a long interval, chosen by a speed input, then waits a short settling time after waking, then asks for one acquisition.

Each accepted acquisition nudges every baseline one step toward its raw sample, and the step rate depends on the direction. A sample below the baseline is a move toward touch. It must persist for more acquisitions before the baseline follows than a sample above the baseline does. Tracking stops on every channel while any key reports detect. A recalibration request restarts the averaging run at any time. It also cuts short a sleep that is in progress. Each channel's delta is its baseline minus its latest sample, so a touch reads as a positive value.

Raw samples arrive on a valid/ready stream. Ready is high only while the block is waiting for the acquisition it requested. A sample offered while ready is low is not taken, and the source must hold it until ready rises.

Top module: `bdt_tracker`

## Requirements
- R1: After reset, `calibrating`, `acq_start` and `smp_ready` are low and every baseline reads 0. `calibrating` rises exactly STARTUP_CYC clock edges after reset is released.
- R2: `acq_start` is a single-cycle pulse, and `smp_ready` is low while it is high. Once `smp_ready` is high, it stays high until a sample is accepted (`smp_valid` and `smp_ready` both high). The first request comes WAKE_CYC edges after `calibrating` rises.
- R3: Calibration takes 2**CAL_LOG2 accepted samples (8 by default). After every accept except the last, `acq_start` pulses on the same edge as the accept. On the edge of the last accept, `calibrating` falls and each baseline becomes floor(sum of its samples / 8).
- R4: Outside calibration, after each accepted sample the next `acq_start` comes exactly sleep + WAKE_CYC edges later. Sleep is FAST_SLEEP_CYC when `speed_fast` is 1 and SLOW_SLEEP_CYC when it is 0.
- R5: For channel c, `delta_out[16c+15:16c]` equals the baseline minus the last accepted sample of that channel, modulo 2**16. It is valid from the edge of the accept onward. Samples are packed the same way: channel c is `smp_data[16c+15:16c]`.
- R6: On TOWARD_ACQ consecutive tracked samples below the baseline, the baseline drops by exactly 1. A baseline never moves by more than 1 per tracked sample.
- R7: On AWAY_ACQ consecutive tracked samples above the baseline, the baseline rises by exactly 1. AWAY_ACQ is smaller than TOWARD_ACQ.
- R8: A tracked sample equal to the baseline, or on the other side of it, clears the channel's run count in the direction that was being counted.
- R9: If any bit of `det_in` is high when a sample is accepted, no baseline changes and no run count advances on any channel.
- R10: A one-cycle `recal_req` raises `calibrating` on the next edge. It ends any sleep within one cycle, so the next request comes WAKE_CYC + 1 edges after the request edge. It leaves the baselines unchanged until the new averaging run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Raw sample word is valid |
| smp_ready | output | 1 | Block is waiting for the requested acquisition |
| smp_data | input | N_CH*W | Raw samples, channel c at bits [W*c+W-1:W*c] |
| det_in | input | N_CH | Per-key detect flags; any high bit freezes tracking |
| recal_req | input | 1 | Pulse to restart calibration |
| speed_fast | input | 1 | 1 selects the short sleep, 0 the long one |
| ref_out | output | N_CH*W | Baselines, channel c at bits [W*c+W-1:W*c] |
| delta_out | output | N_CH*W | Signed baseline minus last sample per channel |
| calibrating | output | 1 | High for the whole averaging run |
| acq_start | output | 1 | One-cycle pulse requesting an acquisition |

## Verification
The assertions assume that the sample source raises `smp_valid` only while it responds to a request. They also assume `recal_req` is a single-cycle pulse and `speed_fast` does not change during a sleep. The bench drives `smp_valid` for exactly one cycle, and only at a falling edge where `smp_ready` is already high. It changes `speed_fast` only in the cycle just before a sample is handed over, and it pulses `recal_req` only while the scheduler is asleep. All checks derive their expected baselines from a small model of the run-count rules and the averaging rule, written separately from the RTL.

// File: rtl/bdt_pkg.sv
`timescale 1ns/1ps
package bdt_pkg;

  typedef enum logic [1:0] {
    PH_BOOT  = 2'd0,
    PH_WAKE  = 2'd1,
    PH_MEAS  = 2'd2,
    PH_SLEEP = 2'd3
  } phase_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bdt_sched.sv
`timescale 1ns/1ps
module bdt_sched
  import bdt_pkg::*;
#(
  parameter int STARTUP_CYC    = 50000,
  parameter int WAKE_CYC       = 500,
  parameter int FAST_SLEEP_CYC = 16000,
  parameter int SLOW_SLEEP_CYC = 64000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic speed_fast,
  input  logic cal_active,
  input  logic accept,
  input  logic cal_after,
  output logic boot_done,
  output logic acq_start,
  output logic meas_open
);
  localparam int MAXC = imax(imax(STARTUP_CYC, WAKE_CYC), imax(FAST_SLEEP_CYC, SLOW_SLEEP_CYC));
  localparam int CW   = $clog2(MAXC + 1);

  phase_t        ph;
  logic [CW-1:0] cnt;
  logic [CW-1:0] sleep_last;

  assign sleep_last = speed_fast ? CW'(FAST_SLEEP_CYC - 1) : CW'(SLOW_SLEEP_CYC - 1);
  assign boot_done  = (ph == PH_BOOT) && (cnt == CW'(STARTUP_CYC - 1));
  assign meas_open  = (ph == PH_MEAS) && !acq_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph        <= PH_BOOT;
      cnt       <= '0;
      acq_start <= 1'b0;
    end else begin
      acq_start <= 1'b0;
      case (ph)
        PH_BOOT: begin
          if (boot_done) begin
            ph  <= PH_WAKE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_WAKE: begin
          if (cnt == CW'(WAKE_CYC - 1)) begin
            ph        <= PH_MEAS;
            cnt       <= '0;
            acq_start <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_MEAS: begin
          if (accept) begin
            if (cal_after) begin
              acq_start <= 1'b1;
            end else begin
              ph  <= PH_SLEEP;
              cnt <= '0;
            end
          end
        end
        default: begin
          if (cal_active || cnt == sleep_last) begin
            ph  <= PH_WAKE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/bdt_chan.sv
`timescale 1ns/1ps
module bdt_chan
  import bdt_pkg::*;
#(
  parameter int W          = 16,
  parameter int CAL_LOG2   = 3,
  parameter int TOWARD_ACQ = 188,
  parameter int AWAY_ACQ   = 63
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         cal_clear,
  input  logic         cal_add,
  input  logic         cal_load,
  input  logic         trk_en,
  input  logic [W-1:0] sample,
  output logic [W-1:0] ref_q,
  output logic [W-1:0] delta
);
  localparam int SW = W + CAL_LOG2;
  localparam int DW = $clog2(imax(TOWARD_ACQ, AWAY_ACQ) + 1);

  logic [SW-1:0] sum_q;
  logic [SW-1:0] sum_nxt;
  logic [W-1:0]  sig_q;
  logic [DW-1:0] dn_q;
  logic [DW-1:0] up_q;

  assign sum_nxt = sum_q + SW'(sample);
  assign delta   = ref_q - sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sig_q <= '0;
    end else if (take) begin
      sig_q <= sample;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q <= '0;
      ref_q <= '0;
      dn_q  <= '0;
      up_q  <= '0;
    end else if (cal_clear) begin
      sum_q <= '0;
      dn_q  <= '0;
      up_q  <= '0;
    end else if (cal_add) begin
      sum_q <= sum_nxt;
    end else if (cal_load) begin
      ref_q <= sum_nxt[SW-1:CAL_LOG2];
      sum_q <= '0;
      dn_q  <= '0;
      up_q  <= '0;
    end else if (trk_en) begin
      if (sample < ref_q) begin
        up_q <= '0;
        if (dn_q == DW'(TOWARD_ACQ - 1)) begin
          ref_q <= ref_q - 1'b1;
          dn_q  <= '0;
        end else begin
          dn_q <= dn_q + 1'b1;
        end
      end else if (sample > ref_q) begin
        dn_q <= '0;
        if (up_q == DW'(AWAY_ACQ - 1)) begin
          ref_q <= ref_q + 1'b1;
          up_q  <= '0;
        end else begin
          up_q <= up_q + 1'b1;
        end
      end else begin
        dn_q <= '0;
        up_q <= '0;
      end
    end
  end

endmodule

// File: rtl/bdt_tracker.sv
`timescale 1ns/1ps
module bdt_tracker
  import bdt_pkg::*;
#(
  parameter int N_CH           = 4,
  parameter int W              = 16,
  parameter int CAL_LOG2       = 3,
  parameter int STARTUP_CYC    = 50000,
  parameter int WAKE_CYC       = 500,
  parameter int FAST_SLEEP_CYC = 16000,
  parameter int SLOW_SLEEP_CYC = 64000,
  parameter int TOWARD_ACQ     = 188,
  parameter int AWAY_ACQ       = 63
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_valid,
  output logic            smp_ready,
  input  logic [N_CH*W-1:0] smp_data,
  input  logic [N_CH-1:0] det_in,
  input  logic            recal_req,
  input  logic            speed_fast,
  output logic [N_CH*W-1:0] ref_out,
  output logic [N_CH*W-1:0] delta_out,
  output logic            calibrating,
  output logic            acq_start
);
  logic                cal_q;
  logic [CAL_LOG2-1:0] cal_cnt;
  logic                boot_done;
  logic                cal_start;
  logic                accept;
  logic                cal_last;
  logic                cal_after;
  logic                meas_open;
  logic                c_add;
  logic                c_load;
  logic                c_trk;

  assign accept    = smp_valid && meas_open;
  assign smp_ready = meas_open;
  assign cal_start = boot_done || recal_req;
  assign cal_last  = (cal_cnt == {CAL_LOG2{1'b1}});
  assign cal_after = cal_start || (cal_q && !cal_last);
  assign c_add     = accept && cal_q && !cal_last && !cal_start;
  assign c_load    = accept && cal_q && cal_last && !cal_start;
  assign c_trk     = accept && !cal_q && !cal_start && !(|det_in);
  assign calibrating = cal_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cal_q   <= 1'b0;
      cal_cnt <= '0;
    end else if (cal_start) begin
      cal_q   <= 1'b1;
      cal_cnt <= '0;
    end else if (accept && cal_q) begin
      cal_cnt <= cal_cnt + 1'b1;
      if (cal_last) cal_q <= 1'b0;
    end
  end

  bdt_sched #(
    .STARTUP_CYC   (STARTUP_CYC),
    .WAKE_CYC      (WAKE_CYC),
    .FAST_SLEEP_CYC(FAST_SLEEP_CYC),
    .SLOW_SLEEP_CYC(SLOW_SLEEP_CYC)
  ) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .speed_fast(speed_fast),
    .cal_active(cal_q),
    .accept    (accept),
    .cal_after (cal_after),
    .boot_done (boot_done),
    .acq_start (acq_start),
    .meas_open (meas_open)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    bdt_chan #(
      .W         (W),
      .CAL_LOG2  (CAL_LOG2),
      .TOWARD_ACQ(TOWARD_ACQ),
      .AWAY_ACQ  (AWAY_ACQ)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (accept),
      .cal_clear(cal_start),
      .cal_add  (c_add),
      .cal_load (c_load),
      .trk_en   (c_trk),
      .sample   (smp_data[c*W +: W]),
      .ref_q    (ref_out[c*W +: W]),
      .delta    (delta_out[c*W +: W])
    );
  end

endmodule

// File: rtl/bdt_checker.sv
`timescale 1ns/1ps
module bdt_checker #(
  parameter int N_CH = 4,
  parameter int W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic [N_CH-1:0]   det_in,
  input logic              recal_req,
  input logic              calibrating,
  input logic              acq_start,
  input logic [N_CH*W-1:0] ref_out
);
  logic acc;
  assign acc = smp_valid && smp_ready;

  assert_acq_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |=> !acq_start);

  assert_ready_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acq_start |-> !smp_ready);

  assert_ready_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ready && !smp_valid) |=> smp_ready);

  assert_cal_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(calibrating) |-> $past(acc));

  assert_recal_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    recal_req |=> calibrating);

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !calibrating && !recal_req && (|det_in)) |=> $stable(ref_out));

  for (genvar c = 0; c < N_CH; c++) begin : g_slew
    assert_ref_slew_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!calibrating && !$past(calibrating)) |->
        (ref_out[c*W +: W] == $past(ref_out[c*W +: W]) ||
         ref_out[c*W +: W] == $past(ref_out[c*W +: W]) + W'(1) ||
         ref_out[c*W +: W] == $past(ref_out[c*W +: W]) - W'(1)));
  end

endmodule

bind bdt_tracker bdt_checker #(.N_CH(N_CH), .W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_valid  (smp_valid),
  .smp_ready  (smp_ready),
  .det_in     (det_in),
  .recal_req  (recal_req),
  .calibrating(calibrating),
  .acq_start  (acq_start),
  .ref_out    (ref_out)
);

// File: tb/tb_bdt_tracker.sv
`timescale 1ns/1ps
module tb_bdt_tracker;
  localparam int NC = 4;
  localparam int W = 16;
  localparam int STARTUP = 20;
  localparam int WAKE = 3;
  localparam int FASTS = 8;
  localparam int SLOWS = 24;
  localparam int TOW = 4;
  localparam int AWY = 2;

  typedef struct packed {
    logic fast;
    logic [3:0] det;
    logic signed [15:0] o0, o1, o2, o3;
  } row_t;

  localparam int NROWS = 12;
  localparam row_t ROWS [NROWS] = '{
    '{1'b1, 4'h0, -16'sd5,  16'sd7,  16'sd1,  16'sd0},
    '{1'b1, 4'h0, -16'sd5,  16'sd7, -16'sd1,  16'sd0},
    '{1'b0, 4'h0, -16'sd5,  16'sd7,  16'sd1,  16'sd0},
    '{1'b0, 4'h2, -16'sd5,  16'sd7, -16'sd1,  16'sd0},
    '{1'b1, 4'h0, -16'sd5,  16'sd7,  16'sd1,  16'sd0},
    '{1'b1, 4'h0, -16'sd5,  16'sd7,  16'sd1,  16'sd0},
    '{1'b1, 4'h0, -16'sd5,  16'sd0,  16'sd1,  16'sd0},
    '{1'b0, 4'h0, -16'sd5,  16'sd7, -16'sd1, -16'sd3},
    '{1'b1, 4'h0, -16'sd5,  16'sd7, -16'sd1, -16'sd3},
    '{1'b1, 4'h8, -16'sd5,  16'sd7, -16'sd1, -16'sd3},
    '{1'b1, 4'h0, -16'sd5,  16'sd7, -16'sd1, -16'sd3},
    '{1'b1, 4'h0, -16'sd5,  16'sd7, -16'sd1, -16'sd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_ready;
  logic [NC*W-1:0] smp_data = '0;
  logic [NC-1:0] det_in = '0;
  logic recal_req = 1'b0;
  logic speed_fast = 1'b1;
  logic [NC*W-1:0] ref_out;
  logic [NC*W-1:0] delta_out;
  logic calibrating;
  logic acq_start;

  int n_tests = 0;
  int n_fail = 0;
  logic [15:0] mref [NC];
  int mdn [NC];
  int mup [NC];
  logic [15:0] cur [NC];

  always #4 clk = ~clk;

  bdt_tracker #(
    .N_CH(NC), .W(W), .CAL_LOG2(3),
    .STARTUP_CYC(STARTUP), .WAKE_CYC(WAKE),
    .FAST_SLEEP_CYC(FASTS), .SLOW_SLEEP_CYC(SLOWS),
    .TOWARD_ACQ(TOW), .AWAY_ACQ(AWY)
  ) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .det_in(det_in), .recal_req(recal_req),
    .speed_fast(speed_fast), .ref_out(ref_out), .delta_out(delta_out),
    .calibrating(calibrating), .acq_start(acq_start)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic take_sample();
    @(negedge clk);
    while (!smp_ready) @(negedge clk);
    for (int c = 0; c < NC; c++) smp_data[c*W +: W] = cur[c];
    smp_valid = 1'b1;
    @(posedge clk);
    #1;
    smp_valid = 1'b0;
  endtask

  task automatic wait_acq(output int n);
    n = 0;
    while (!acq_start && n < 1000) begin
      @(posedge clk);
      #1;
      n++;
    end
  endtask

  task automatic model_step(input int c, input logic [15:0] s);
    if (s < mref[c]) begin
      mup[c] = 0;
      if (mdn[c] == TOW - 1) begin mref[c] = mref[c] - 16'd1; mdn[c] = 0; end
      else mdn[c]++;
    end else if (s > mref[c]) begin
      mdn[c] = 0;
      if (mup[c] == AWY - 1) begin mref[c] = mref[c] + 16'd1; mup[c] = 0; end
      else mup[c]++;
    end else begin
      mdn[c] = 0;
      mup[c] = 0;
    end
  endtask

  task automatic check_refs(input string req);
    for (int c = 0; c < NC; c++) check(req, ref_out[c*W +: W], mref[c]);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    logic [15:0] base [NC];
    base[0] = 16'd1000; base[1] = 16'd2000; base[2] = 16'd30000; base[3] = 16'd65000;
    for (int c = 0; c < NC; c++) begin mdn[c] = 0; mup[c] = 0; end

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 cal", calibrating, 0);
    check("R1 acq", acq_start, 0);
    check("R1 ready", smp_ready, 0);
    check("R1 ref", ref_out, 0);
    n = 0;
    while (!calibrating && n < 1000) begin @(posedge clk); #1; n++; end
    check("R1 startup", n, STARTUP);
    wait_acq(n);
    check("R2 wake", n, WAKE);
    check("R2 ready low with pulse", smp_ready, 0);
    @(posedge clk); #1;
    check("R2 pulse width", acq_start, 0);

    // R3: calibration run
    speed_fast = 1'b1;
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < NC; c++) cur[c] = base[c] + 16'(k);
      take_sample();
      if (k < 7) begin
        check("R3 busy", calibrating, 1);
        check("R3 back-to-back", acq_start, 1);
      end
    end
    check("R3 done", calibrating, 0);
    for (int c = 0; c < NC; c++) begin
      mref[c] = base[c] + 16'd3;
      check("R3 mean", ref_out[c*W +: W], mref[c]);
      check("R5 delta", delta_out[c*W +: W], 16'(mref[c] - cur[c]));
    end
    wait_acq(n);
    check("R4 fast gap", n, FASTS + WAKE);

    // Table walk: R4..R9
    for (int r = 0; r < NROWS; r++) begin
      speed_fast = ROWS[r].fast;
      det_in = ROWS[r].det;
      cur[0] = 16'(mref[0] + ROWS[r].o0);
      cur[1] = 16'(mref[1] + ROWS[r].o1);
      cur[2] = 16'(mref[2] + ROWS[r].o2);
      cur[3] = 16'(mref[3] + ROWS[r].o3);
      take_sample();
      if (ROWS[r].det == 4'h0)
        for (int c = 0; c < NC; c++) model_step(c, cur[c]);
      check_refs(ROWS[r].det != 0 ? "R9 freeze" : "R6 R7 R8 track");
      for (int c = 0; c < NC; c++)
        check("R5 delta", delta_out[c*W +: W], 16'(mref[c] - cur[c]));
      wait_acq(n);
      check(ROWS[r].fast ? "R4 fast gap" : "R4 slow gap", n,
            (ROWS[r].fast ? FASTS : SLOWS) + WAKE);
    end
    det_in = '0;

    // R10: recalibration cuts sleep short
    speed_fast = 1'b0;
    for (int c = 0; c < NC; c++) cur[c] = mref[c];
    take_sample();
    repeat (2) @(posedge clk);
    @(negedge clk);
    recal_req = 1'b1;
    @(posedge clk); #1;
    recal_req = 1'b0;
    check("R10 flag", calibrating, 1);
    check_refs("R10 hold");
    wait_acq(n);
    check("R10 wake", n, WAKE + 1);
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < NC; c++) cur[c] = 16'd500 + 16'(c * 8 + k);
      take_sample();
      if (k == 3) check_refs("R10 hold mid-run");
    end
    check("R10 end", calibrating, 0);
    for (int c = 0; c < NC; c++) begin
      mref[c] = 16'd500 + 16'(c * 8) + 16'd3;
      check("R10 R3 new mean", ref_out[c*W +: W], mref[c]);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule